// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block watches a 32-bit address bus and raises a break request when a bus cycle meets a set of programmed conditions. Each cycle arrives with a valid strobe, its address, a flag for the master that issued it (the CPU or the DMA/transfer controller) and a flag that tells an instruction fetch from a data access. The conditions are a break address, a per-bit address mask and a condition register that holds two 2-bit selects. One select picks the allowed masters and the other picks the allowed access types. In each select the value 00 turns the break off.

Software sets the conditions through a simple write/read register port. The read port is combinational. When a cycle matches, the block drives a one-clock break request on the next cycle and sets a sticky status flag. The flag stays set until software writes 1 to clear it. A typical use is to halt execution when a given code or data region is touched. The mask lets one compare cover a block of addresses.

Top module: `brk_match`

## Requirements
- R1: After reset the break address, both mask halves, the condition register and the sticky flag all read 0. With these values no bus cycle causes a break.
- R2: The master select is condition bits [7:6]. 00 allows no cycle, 01 allows CPU cycles only (bus_dma=0), 10 allows DMA cycles only (bus_dma=1), and 11 allows both masters.
- R3: The access select is condition bits [5:4]. 00 allows no cycle, 01 allows instruction fetches only (bus_data=0), 10 allows data accesses only (bus_data=1), and 11 allows both.
- R4: The address matches when ((bus_addr ^ break_addr) & ~mask) == 0. A mask bit of 1 removes that address bit from the compare. Register offset 1 holds mask bits [31:16] in wdata[15:0], and offset 2 holds mask bits [15:0] in wdata[15:0].
- R5: With every mask bit set to 1, any address matches.
- R6: In the condition register (offset 3), bits [15:8] and [3:0] read as 0 and written values there are not stored. Bits [31:16] of rdata also read 0 at this offset.
- R7: brk_req is high for exactly the one clock that follows a valid matching cycle. A cycle with bus_valid=0 never causes a break.
- R8: The sticky flag is status bit 0 at offset 4 and also drives the brk_sticky port. It is set together with brk_req. Writing 1 to bit 0 clears it and writing 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset: 0 address, 1 mask high, 2 mask low, 3 condition, 4 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Bus cycle valid |
| bus_addr | input | 32 | Bus cycle address |
| bus_dma | input | 1 | 1 = DMA/transfer-controller cycle, 0 = CPU cycle |
| bus_data | input | 1 | 1 = data access, 0 = instruction fetch |
| brk_req | output | 1 | One-clock break request |
| brk_sticky | output | 1 | Sticky break status |

## Verification
A corrupted select field or mask bit shows up at the ports one clock after the first cycle that the bad field decides. A break is then either missed or raised without cause. The directed tests cover each select encoding and each mask half, so these faults are exposed at once. A stuck or lost sticky flag is seen on brk_sticky and on the status read in the same clock as the pulse or the clear write. Reserved-bit storage is seen directly on the next read of the condition register.

// File: rtl/brk_match.sv
module brk_match #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_dma,
  input  logic          bus_data,
  output logic          brk_req,
  output logic          brk_sticky
);
  localparam int HW = AW / 2;

  logic [AW-1:0] brk_addr;
  logic [AW-1:0] mask;
  logic [1:0]    ms_sel;
  logic [1:0]    as_sel;
  logic          hit;

  wire wr_addr = reg_wr && reg_addr == 3'd0;
  wire wr_mhi  = reg_wr && reg_addr == 3'd1;
  wire wr_mlo  = reg_wr && reg_addr == 3'd2;
  wire wr_cond = reg_wr && reg_addr == 3'd3;
  wire wr_clr  = reg_wr && reg_addr == 3'd4 && reg_wdata[0];

  wire master_ok = bus_dma  ? ms_sel[1] : ms_sel[0];
  wire access_ok = bus_data ? as_sel[1] : as_sel[0];
  wire addr_ok   = ((bus_addr ^ brk_addr) & ~mask) == '0;

  assign hit = bus_valid && master_ok && access_ok && addr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_addr <= '0;
      mask     <= '0;
      ms_sel   <= 2'b00;
      as_sel   <= 2'b00;
    end else begin
      if (wr_addr) brk_addr <= reg_wdata[AW-1:0];
      if (wr_mhi)  mask[AW-1:HW] <= reg_wdata[HW-1:0];
      if (wr_mlo)  mask[HW-1:0]  <= reg_wdata[HW-1:0];
      if (wr_cond) begin
        ms_sel <= reg_wdata[7:6];
        as_sel <= reg_wdata[5:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_req    <= 1'b0;
      brk_sticky <= 1'b0;
    end else begin
      brk_req <= hit;
      if (hit)         brk_sticky <= 1'b1;
      else if (wr_clr) brk_sticky <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0:    reg_rdata[AW-1:0] = brk_addr;
      3'd1:    reg_rdata[HW-1:0] = mask[AW-1:HW];
      3'd2:    reg_rdata[HW-1:0] = mask[HW-1:0];
      3'd3:    reg_rdata[7:4]    = {ms_sel, as_sel};
      3'd4:    reg_rdata[0]      = brk_sticky;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module brk_match_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_dma,
  input logic          bus_data,
  input logic          brk_req,
  input logic          brk_sticky,
  input logic [AW-1:0] brk_addr,
  input logic [AW-1:0] mask,
  input logic [1:0]    ms_sel,
  input logic [1:0]    as_sel
);
  AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_valid)); // R7
  AST_MASTER_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> ($past(bus_dma) ? $past(ms_sel[1]) : $past(ms_sel[0]))); // R2
  AST_ACCESS_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> ($past(bus_data) ? $past(as_sel[1]) : $past(as_sel[0]))); // R3
  AST_ADDR_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> ((($past(bus_addr) ^ $past(brk_addr)) & ~$past(mask)) == '0)); // R4
  AST_STICKY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> brk_sticky); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd3) |-> (reg_rdata[DW-1:8] == '0 && reg_rdata[3:0] == 4'h0)); // R6
endmodule

bind brk_match brk_match_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_dma(bus_dma),
  .bus_data(bus_data), .brk_req(brk_req), .brk_sticky(brk_sticky),
  .brk_addr(brk_addr), .mask(mask), .ms_sel(ms_sel), .as_sel(as_sel)
);

// File: tb/brk_match_test.sv
`timescale 1ns/1ps
module brk_match_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_dma = 1'b0;
  logic        bus_data = 1'b0;
  logic        brk_req;
  logic        brk_sticky;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] s_addr, s_mask;
  logic [1:0]  s_ms, s_as;

  always #2.5 clk = ~clk;

  brk_match uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic setup(input logic [31:0] a, input logic [31:0] m, input logic [1:0] ms, input logic [1:0] as_);
    s_addr = a; s_mask = m; s_ms = ms; s_as = as_;
    wr(3'd0, a);
    wr(3'd1, {16'h0, m[31:16]});
    wr(3'd2, {16'h0, m[15:0]});
    wr(3'd3, {24'h0, ms, as_, 4'h0});
  endtask

  function automatic logic ref_match(input logic v, input logic [31:0] a, input logic dma, input logic dat);
    logic mok, aok;
    mok = dma ? s_ms[1] : s_ms[0];
    aok = dat ? s_as[1] : s_as[0];
    return v && mok && aok && (((a ^ s_addr) & ~s_mask) == 32'h0);
  endfunction

  task automatic cyc(input string req, input logic v, input logic [31:0] a, input logic dma, input logic dat);
    logic e;
    e = ref_match(v, a, dma, dat);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_dma = dma; bus_data = dat;
    @(posedge clk); #1;
    bus_valid = 1'b0;
    chk(req, {31'h0, brk_req}, {31'h0, e});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      rd(i[2:0], d);
      chk("R1 reset reg", d, 32'h0);
    end
    s_addr = 0; s_mask = 0; s_ms = 0; s_as = 0;
    cyc("R1 no break after reset", 1'b1, 32'h0, 1'b0, 1'b0);
    cyc("R1 no break after reset", 1'b1, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d);
    chk("R6 reserved bits dropped", d, 32'h0000_00F0);
    wr(3'd3, 32'hFFFF_FF0F);
    rd(3'd3, d);
    chk("R6 reserved only write", d, 32'h0);
  endtask

  task automatic t_masters;
    for (int ms = 0; ms < 4; ms++) begin
      setup(32'h1234_5678, 32'h0, ms[1:0], 2'b11);
      cyc("R2 cpu cycle", 1'b1, 32'h1234_5678, 1'b0, 1'b0);
      cyc("R2 dma cycle", 1'b1, 32'h1234_5678, 1'b1, 1'b1);
    end
  endtask

  task automatic t_access;
    for (int as_ = 0; as_ < 4; as_++) begin
      setup(32'hA000_0010, 32'h0, 2'b11, as_[1:0]);
      cyc("R3 fetch", 1'b1, 32'hA000_0010, 1'b0, 1'b0);
      cyc("R3 data", 1'b1, 32'hA000_0010, 1'b1, 1'b1);
    end
  endtask

  task automatic t_mask;
    setup(32'hDEAD_BE00, 32'h0000_00FF, 2'b11, 2'b11);
    cyc("R4 low byte masked", 1'b1, 32'hDEAD_BE7C, 1'b0, 1'b1);
    cyc("R4 bit 8 differs", 1'b1, 32'hDEAD_BF00, 1'b0, 1'b1);
    setup(32'hDEAD_BE00, 32'hFFFF_0000, 2'b11, 2'b11);
    cyc("R4 upper half masked", 1'b1, 32'h0000_BE00, 1'b1, 1'b0);
    cyc("R4 lower bit differs", 1'b1, 32'h0000_BE01, 1'b1, 1'b0);
    cyc("R4 exact no mask bit", 1'b1, 32'hDEAD_BE00, 1'b1, 1'b0);
  endtask

  task automatic t_allmask;
    setup(32'h0, 32'hFFFF_FFFF, 2'b11, 2'b11);
    cyc("R5 all mask any addr", 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    cyc("R5 all mask any addr", 1'b1, 32'h5A5A_0F0F, 1'b1, 1'b1);
    setup(32'h0, 32'hFFFF_FFFF, 2'b00, 2'b11);
    cyc("R5 all mask but master off", 1'b1, 32'h1, 1'b0, 1'b0);
    setup(32'h0, 32'hFFFF_FFFF, 2'b11, 2'b00);
    cyc("R5 all mask but access off", 1'b1, 32'h1, 1'b0, 1'b0);
  endtask

  task automatic t_pulse_sticky;
    logic [31:0] d;
    setup(32'h0000_4000, 32'h0, 2'b01, 2'b01);
    wr(3'd4, 32'h1);
    cyc("R7 invalid never breaks", 1'b0, 32'h0000_4000, 1'b0, 1'b0);
    chk("R8 sticky clear before hit", {31'h0, brk_sticky}, 32'h0);
    cyc("R7 match pulse", 1'b1, 32'h0000_4000, 1'b0, 1'b0);
    chk("R8 sticky set with req", {31'h0, brk_sticky}, 32'h1);
    @(posedge clk); #1;
    chk("R7 pulse one clock", {31'h0, brk_req}, 32'h0);
    wr(3'd4, 32'h0);
    rd(3'd4, d);
    chk("R8 write 0 keeps flag", d, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, d);
    chk("R8 write 1 clears", d, 32'h0);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 32'h0000_4000; bus_dma = 1'b0; bus_data = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
    @(posedge clk); #1;
    bus_valid = 1'b0; reg_wr = 1'b0;
    chk("R8 set wins over clear", {31'h0, brk_sticky}, 32'h1);
    wr(3'd4, 32'h1);
  endtask

  task automatic t_random;
    for (int k = 0; k < 20; k++) begin
      logic [31:0] a, m;
      a = $urandom;
      m = $urandom | $urandom;
      setup(a, m, 2'($urandom), 2'($urandom));
      for (int j = 0; j < 20; j++) begin
        logic [31:0] ba;
        ba = (j % 2 == 0) ? (a ^ (m & $urandom)) : $urandom;
        cyc("R4 random", 1'($urandom), ba, 1'($urandom), 1'($urandom));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_masters();
    t_access();
    t_mask();
    t_allmask();
    t_pulse_sticky();
    t_random();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule